// File: doc/BRIEF.md
# Non-blocking critical metadata updater

This stage sits beside the filter stage of an event-filtering pipeline and keeps the small, filtering-critical slice of metadata current in hardware. Each event arrives with three operands (two sources and one destination), each either a register or a memory location. The stage resolves the current critical metadata of every operand. In the same cycle it computes a new destination value from the event's update rule.

When the external filter decision marks the event as unfilterable, the new value is committed one cycle later in a metadata-write stage. Register destinations go into an internal register-metadata file. Memory destinations go into a small filter store queue that shadows the metadata cache until the software handler for that event reports completion. Later reads prefer the write stage, then the youngest matching queue entry, then the cache data presented with the event. Dependent events can therefore be filtered while the handler is still running.

Top module: `critmd_updater`

## Requirements
- R1: The rule field selects the new value: 0 gives no update, 1 copies s1, 2 copies s2, 3 is s1 OR s2, 4 is s1 AND s2, 5 loads the invariant register chosen by the selector, and 6 and 7 give no update. `upd_en`/`upd_md` report the result for every valid event.
- R2: The condition field gates the update. 0 always applies it, 1 requires s1 equal to s2, 2 requires s1 equal to the destination's current value, and 3 requires s1 equal to the selected invariant. A failed condition gives no update.
- R3: An event marked filtered commits nothing. A later read of its destination returns the old value.
- R4: An unfilterable event with a register destination (operand memory bit 0, low bits of the id index the file) writes the register-metadata file, and later reads of that register return the value.
- R5: An unfilterable event with a memory destination (memory bit 1) enters the filter store queue. A later memory read of that address returns the queued value instead of the cache input.
- R6: When several queue entries hold the same address, the youngest one is returned.
- R7: An event directly after a committing event sees the committed value on any operand naming that destination.
- R8: Each `hdl_done` pulse retires the oldest queue entry. Once all entries for an address are retired, reads of that address return the cache input.
- R9: `ev_ready` is low exactly when the presented event is valid, unfiltered and updating, has a memory destination, and the queue, counting the entry in the write stage, already holds `FSQ_DEPTH` entries. A completion in that same cycle does not lift the stall.
- R10: After reset the register-metadata file reads zero, the queue is empty and `ev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present in filter stage |
| ev_ready | output | 1 | Event accepted this cycle |
| ev_filtered | input | 1 | Filter decision: 1 means filtered |
| ev_rule | input | 3 | Update rule code |
| ev_cond | input | 2 | Condition code |
| ev_inv_sel | input | $clog2(NINV) | Invariant register selector |
| ev_s1_mem | input | 1 | s1 is memory |
| ev_s1_id | input | ID_W | s1 register index or address |
| ev_s2_mem | input | 1 | s2 is memory |
| ev_s2_id | input | ID_W | s2 register index or address |
| ev_d_mem | input | 1 | Destination is memory |
| ev_d_id | input | ID_W | Destination register index or address |
| cache_s1_md | input | MD_W | Cache metadata for s1 |
| cache_s2_md | input | MD_W | Cache metadata for s2 |
| cache_d_md | input | MD_W | Cache metadata for destination |
| inv_values | input | NINV*MD_W | Invariant registers, entry k at bits k*MD_W |
| hdl_done | input | 1 | Handler completion, retires oldest entry |
| s1_md | output | MD_W | Resolved s1 metadata |
| s2_md | output | MD_W | Resolved s2 metadata |
| d_md | output | MD_W | Resolved destination metadata |
| upd_en | output | 1 | Rule yields a new value |
| upd_md | output | MD_W | New destination value |

## Verification
The assertions assume two things about the environment. A completion arrives only for an unfiltered event that has already left the write stage, so no completion meets an empty queue. The cache inputs reflect memory state with every retired queue entry already applied. The bench meets both conditions. It raises `hdl_done` only when its model holds an entry older than the one pushed in the previous cycle. On each retirement it writes the retired value into its cache model, and the cache inputs are driven from that model. Random events use a few registers and addresses so that queue hits, repeated addresses and stalls occur often.

// File: rtl/critmd_updater.sv
module critmd_updater #(
  parameter int MD_W      = 8,
  parameter int ID_W      = 16,
  parameter int NREG      = 32,
  parameter int NINV      = 4,
  parameter int FSQ_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_valid,
  output logic                      ev_ready,
  input  logic                      ev_filtered,
  input  logic [2:0]                ev_rule,
  input  logic [1:0]                ev_cond,
  input  logic [$clog2(NINV)-1:0]   ev_inv_sel,
  input  logic                      ev_s1_mem,
  input  logic [ID_W-1:0]           ev_s1_id,
  input  logic                      ev_s2_mem,
  input  logic [ID_W-1:0]           ev_s2_id,
  input  logic                      ev_d_mem,
  input  logic [ID_W-1:0]           ev_d_id,
  input  logic [MD_W-1:0]           cache_s1_md,
  input  logic [MD_W-1:0]           cache_s2_md,
  input  logic [MD_W-1:0]           cache_d_md,
  input  logic [NINV*MD_W-1:0]      inv_values,
  input  logic                      hdl_done,
  output logic [MD_W-1:0]           s1_md,
  output logic [MD_W-1:0]           s2_md,
  output logic [MD_W-1:0]           d_md,
  output logic                      upd_en,
  output logic [MD_W-1:0]           upd_md
);
  localparam int REG_AW = $clog2(NREG);
  localparam int PTR_W  = $clog2(FSQ_DEPTH);
  localparam int CNT_W  = PTR_W + 1;

  logic [MD_W-1:0]  rf      [NREG];
  logic [ID_W-1:0]  fq_addr [FSQ_DEPTH];
  logic [MD_W-1:0]  fq_md   [FSQ_DEPTH];
  logic [PTR_W-1:0] fq_head, fq_tail;
  logic [CNT_W-1:0] fq_cnt;

  logic             mw_valid, mw_mem;
  logic [ID_W-1:0]  mw_id;
  logic [MD_W-1:0]  mw_md;

  function automatic logic [MD_W:0] fsq_find(input logic [ID_W-1:0] a);
    logic [MD_W:0] r;
    r = '0;
    for (int i = 0; i < FSQ_DEPTH; i++) begin
      logic [PTR_W-1:0] idx;
      idx = fq_head + PTR_W'(i);
      if (CNT_W'(i) < fq_cnt && fq_addr[idx] == a) r = {1'b1, fq_md[idx]};
    end
    return r;
  endfunction

  function automatic logic [MD_W-1:0] resolve(input logic m, input logic [ID_W-1:0] id,
                                              input logic [MD_W-1:0] cmd);
    logic [MD_W:0] f;
    logic          fwd;
    fwd = mw_valid && (mw_mem == m) &&
          (m ? (mw_id == id) : (mw_id[REG_AW-1:0] == id[REG_AW-1:0]));
    f = fsq_find(id);
    if (fwd)        return mw_md;
    else if (!m)    return rf[id[REG_AW-1:0]];
    else if (f[MD_W]) return f[MD_W-1:0];
    else            return cmd;
  endfunction

  logic [MD_W-1:0] inv_md;
  logic            cond_ok, rule_on;
  logic [MD_W-1:0] rule_val;

  assign s1_md  = resolve(ev_s1_mem, ev_s1_id, cache_s1_md);
  assign s2_md  = resolve(ev_s2_mem, ev_s2_id, cache_s2_md);
  assign d_md   = resolve(ev_d_mem,  ev_d_id,  cache_d_md);
  assign inv_md = inv_values[int'(ev_inv_sel)*MD_W +: MD_W];

  always_comb begin
    case (ev_cond)
      2'd1:    cond_ok = (s1_md == s2_md);
      2'd2:    cond_ok = (s1_md == d_md);
      2'd3:    cond_ok = (s1_md == inv_md);
      default: cond_ok = 1'b1;
    endcase
    rule_on  = 1'b1;
    case (ev_rule)
      3'd1:    rule_val = s1_md;
      3'd2:    rule_val = s2_md;
      3'd3:    rule_val = s1_md | s2_md;
      3'd4:    rule_val = s1_md & s2_md;
      3'd5:    rule_val = inv_md;
      default: begin rule_val = '0; rule_on = 1'b0; end
    endcase
  end

  assign upd_en = ev_valid && rule_on && cond_ok;
  assign upd_md = rule_val;

  logic             need_push, commit, fq_pop, fq_push;
  logic [CNT_W-1:0] eff_cnt;

  assign need_push = upd_en && !ev_filtered && ev_d_mem;
  assign eff_cnt   = fq_cnt + CNT_W'(mw_valid && mw_mem);
  assign ev_ready  = !(need_push && eff_cnt >= CNT_W'(FSQ_DEPTH));
  assign commit    = ev_valid && ev_ready && !ev_filtered && upd_en;
  assign fq_push   = mw_valid && mw_mem;
  assign fq_pop    = hdl_done && (fq_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mw_valid <= 1'b0;
      mw_mem   <= 1'b0;
      mw_id    <= '0;
      mw_md    <= '0;
    end else begin
      mw_valid <= commit;
      mw_mem   <= ev_d_mem;
      mw_id    <= ev_d_id;
      mw_md    <= rule_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (mw_valid && !mw_mem) begin
      rf[mw_id[REG_AW-1:0]] <= mw_md;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fq_head <= '0;
      fq_tail <= '0;
      fq_cnt  <= '0;
      for (int i = 0; i < FSQ_DEPTH; i++) begin
        fq_addr[i] <= '0;
        fq_md[i]   <= '0;
      end
    end else begin
      if (fq_push) begin
        fq_addr[fq_tail] <= mw_id;
        fq_md[fq_tail]   <= mw_md;
        fq_tail          <= fq_tail + 1'b1;
      end
      if (fq_pop) fq_head <= fq_head + 1'b1;
      fq_cnt <= fq_cnt + CNT_W'(fq_push) - CNT_W'(fq_pop);
    end
  end

  // R9
  fsq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_cnt <= CNT_W'(FSQ_DEPTH));

  // R9
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fq_push |-> (fq_cnt < CNT_W'(FSQ_DEPTH)) || hdl_done);

  // R3
  filtered_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_filtered) |=> !mw_valid);

  // R8
  done_has_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdl_done |-> fq_cnt != '0);

  // R4
  rf_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_mem) |=> rf[$past(mw_id[REG_AW-1:0])] == $past(mw_md));

endmodule

// File: tb/critmd_updater_tb.sv
module critmd_updater_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       ev_valid, ev_filtered, ev_s1_mem, ev_s2_mem, ev_d_mem, hdl_done;
  logic [2:0] ev_rule;
  logic [1:0] ev_cond, ev_inv_sel;
  logic [15:0] ev_s1_id, ev_s2_id, ev_d_id;
  logic [7:0] cache_s1_md, cache_s2_md, cache_d_md;
  logic [31:0] inv_values = {8'h01, 8'hFF, 8'h5A, 8'h00};
  logic       ev_ready, upd_en;
  logic [7:0] s1_md, s2_md, d_md, upd_md;

  critmd_updater u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_filtered(ev_filtered), .ev_rule(ev_rule), .ev_cond(ev_cond),
    .ev_inv_sel(ev_inv_sel), .ev_s1_mem(ev_s1_mem), .ev_s1_id(ev_s1_id),
    .ev_s2_mem(ev_s2_mem), .ev_s2_id(ev_s2_id), .ev_d_mem(ev_d_mem),
    .ev_d_id(ev_d_id), .cache_s1_md(cache_s1_md), .cache_s2_md(cache_s2_md),
    .cache_d_md(cache_d_md), .inv_values(inv_values), .hdl_done(hdl_done),
    .s1_md(s1_md), .s2_md(s2_md), .d_md(d_md), .upd_en(upd_en), .upd_md(upd_md));

  int checks = 0, fails = 0;
  logic [7:0] m_rf [32];
  logic [7:0] m_cache [16];
  logic [15:0] qa [4];
  logic [7:0]  qm [4];
  int qn = 0;
  bit pushed_prev = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_res(input logic m, input logic [15:0] id);
    if (!m) return m_rf[id[4:0]];
    for (int i = qn - 1; i >= 0; i--) if (qa[i] == id) return qm[i];
    return m_cache[id[3:0]];
  endfunction

  function automatic logic [8:0] m_rule(input logic [2:0] r, input logic [1:0] c,
      input logic [1:0] sel, input logic [7:0] a, input logic [7:0] b, input logic [7:0] d);
    logic [7:0] iv;
    logic ok;
    iv = inv_values[sel*8 +: 8];
    case (c)
      2'd1: ok = (a == b);
      2'd2: ok = (a == d);
      2'd3: ok = (a == iv);
      default: ok = 1'b1;
    endcase
    case (r)
      3'd1: return {ok, a};
      3'd2: return {ok, b};
      3'd3: return {ok, a | b};
      3'd4: return {ok, a & b};
      3'd5: return {ok, iv};
      default: return 9'h000;
    endcase
  endfunction

  task automatic step(input bit v, input bit f, input logic [2:0] r, input logic [1:0] c,
      input logic [1:0] sel, input bit am, input int aid, input bit bm, input int bid,
      input bit dm, input int did, input bit want_done, input string tag);
    logic [7:0] ea, eb, ed;
    logic [8:0] er;
    bit exp_ready, acc, dn, push;
    @(negedge clk);
    ev_valid = v; ev_filtered = f; ev_rule = r; ev_cond = c; ev_inv_sel = sel;
    ev_s1_mem = am; ev_s1_id = 16'(aid); ev_s2_mem = bm; ev_s2_id = 16'(bid);
    ev_d_mem = dm; ev_d_id = 16'(did);
    cache_s1_md = am ? m_cache[aid[3:0]] : 8'h00;
    cache_s2_md = bm ? m_cache[bid[3:0]] : 8'h00;
    cache_d_md  = dm ? m_cache[did[3:0]] : 8'h00;
    dn = want_done && ((qn - int'(pushed_prev)) > 0);
    hdl_done = dn;
    #5;
    ea = m_res(am, 16'(aid)); eb = m_res(bm, 16'(bid)); ed = m_res(dm, 16'(did));
    er = v ? m_rule(r, c, sel, ea, eb, ed) : 9'h000;
    exp_ready = !(er[8] && !f && dm && qn == 4);
    chk(ev_ready == exp_ready, {tag, " R9 ready"}, ev_ready, exp_ready);
    if (v) begin
      chk(s1_md == ea, {tag, " R4 R5 R6 R7 R8 s1"}, s1_md, ea);
      chk(s2_md == eb, {tag, " R4 R5 R6 R7 R8 s2"}, s2_md, eb);
      chk(d_md == ed,  {tag, " R4 R5 R6 R7 R8 d"}, d_md, ed);
      chk(upd_en == er[8], {tag, " R1 R2 upd_en"}, upd_en, er[8]);
      if (er[8]) chk(upd_md == er[7:0], {tag, " R1 upd_md"}, upd_md, er[7:0]);
    end
    acc = v && exp_ready;
    if (dn) begin
      m_cache[qa[0][3:0]] = qm[0];
      for (int i = 0; i < 3; i++) begin qa[i] = qa[i+1]; qm[i] = qm[i+1]; end
      qn--;
    end
    push = 0;
    if (acc && !f && er[8]) begin
      if (dm) begin qa[qn] = 16'(did); qm[qn] = er[7:0]; qn++; push = 1; end
      else m_rf[did[4:0]] = er[7:0];
    end
    pushed_prev = push;
    @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = 8'h00;
    for (int i = 0; i < 16; i++) m_cache[i] = 8'(8'h80 + i);
    ev_valid = 0; ev_filtered = 0; ev_rule = 0; ev_cond = 0; ev_inv_sel = 0;
    ev_s1_mem = 0; ev_s2_mem = 0; ev_d_mem = 0; ev_s1_id = 0; ev_s2_id = 0; ev_d_id = 0;
    cache_s1_md = 0; cache_s2_md = 0; cache_d_md = 0; hdl_done = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 reset state
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle");
    step(1, 0, 0, 0, 0, 0, 3, 0, 7, 0, 9, 0, "R10 regs zero");
    // R1 constant loads, R7 back-to-back read
    step(1, 0, 5, 0, 1, 0, 0, 0, 0, 0, 1, 0, "R1 const");
    step(1, 0, 5, 0, 2, 0, 0, 0, 0, 0, 2, 0, "R1 const");
    step(1, 0, 3, 0, 0, 0, 2, 0, 1, 0, 3, 0, "R7 R1 or");
    step(1, 0, 4, 0, 0, 0, 3, 0, 1, 0, 4, 0, "R1 and");
    step(1, 0, 1, 0, 0, 0, 4, 0, 2, 0, 5, 0, "R1 copy1");
    step(1, 0, 2, 0, 0, 0, 4, 0, 2, 0, 6, 0, "R1 copy2");
    step(1, 0, 6, 0, 0, 0, 1, 0, 2, 0, 7, 0, "R1 none");
    // R2 conditions
    step(1, 0, 5, 1, 3, 0, 1, 0, 2, 0, 1, 0, "R2 fail");
    step(1, 0, 5, 3, 1, 0, 1, 0, 2, 0, 6, 0, "R2 pass");
    step(1, 0, 5, 2, 3, 0, 6, 0, 2, 0, 6, 0, "R2 dest");
    // R3 filtered event
    step(1, 1, 5, 0, 3, 0, 0, 0, 0, 0, 1, 0, "R3 filt");
    step(1, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R3 read");
    // R5 R6 memory destinations
    step(1, 0, 5, 0, 1, 0, 0, 0, 0, 1, 4, 0, "R5 push");
    step(1, 0, 5, 0, 3, 0, 0, 0, 0, 1, 4, 0, "R6 push");
    step(1, 0, 0, 0, 0, 1, 4, 1, 5, 1, 4, 0, "R6 youngest");
    step(1, 0, 5, 0, 2, 0, 0, 0, 0, 1, 5, 0, "R5 push");
    step(1, 0, 5, 0, 0, 0, 0, 0, 0, 1, 6, 0, "R5 push");
    // R9 full stall, completion same cycle does not lift it
    step(1, 0, 5, 0, 1, 0, 0, 0, 0, 1, 7, 1, "R9 stall");
    step(1, 0, 5, 0, 1, 0, 0, 0, 0, 1, 7, 0, "R9 resume");
    // R8 retire in order, cache serves afterwards
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 done");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 done");
    step(1, 0, 0, 0, 0, 1, 4, 1, 5, 1, 6, 1, "R8 read");
    step(1, 0, 0, 0, 0, 1, 5, 1, 6, 1, 7, 1, "R8 read");
    step(1, 0, 0, 0, 0, 1, 4, 1, 5, 1, 7, 0, "R8 cache");
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1), 3'($urandom_range(0, 7)),
           2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
           $urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 7),
           $urandom_range(0, 3) == 0, "rand");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule